// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block picks the one most urgent pending interrupt out of a bank of sources. Each source carries a programmed priority byte, a non-maskable flag and a security group bit. A start pulse launches a sweep. The sweep visits one source per clock in ascending index order and keeps a running best candidate. It then weighs one extra candidate supplied from outside the block, such as the winner of a message-signalled interrupt search. The final choice is published with a one-cycle done pulse.

Non-maskable sources do not use their programmed byte. Their effective priority is forced to a fixed level that depends on a global security-disable bit and on the source's group. They beat ordinary sources at the same numeric level. Only when priority and flag are both equal does the lower interrupt number win. A small register-style write port loads the per-source settings and the global bit. A start request that arrives mid-sweep is remembered and runs one more sweep as soon as the current one completes.

Top module: `irq_pick_top`

## Requirements
- R1: A candidate whose effective priority is numerically lower replaces the running best, and one whose priority is higher never does, whatever the non-maskable flags are.
- R2: When the effective priorities are equal and exactly one of the two candidates is non-maskable, the non-maskable one wins.
- R3: When priority and flag are both equal, the candidate with the lower or equal interrupt number wins. A source's interrupt number is its index.
- R4: A non-maskable source has effective priority 0x80 when the global security-disable bit is 0 and its group bit is 1 (non-secure). In every other case its effective priority is 0x00.
- R5: A source that is not non-maskable competes with its programmed priority byte unchanged.
- R6: After reset the outputs are: id all ones, priority 0xFF, flag 0, valid 0, done 0 and busy 0. Every sweep starts from this empty candidate, so results from an earlier sweep never carry over.
- R7: The external candidate takes part only when `ext_en` is 1 and `ext_prio` is not 0xFF. It always competes as not non-maskable, and it is weighed after the last source.
- R8: A source whose `pend` bit is 0 is skipped and never changes the result.
- R9: A start accepted at a rising edge while idle produces `done` high for exactly one cycle, following the NUM_SRC+1-th rising edge after the accepting one. The result outputs change only at that same edge.
- R10: `best_valid` is 1 exactly when the published priority is not 0xFF.
- R11: A start that arrives during a sweep (including the external-compare cycle) is latched. Exactly one more sweep then begins at the edge that raises `done`, and further starts during the same sweep merge into that one request.
- R12: Config writes act at the rising edge when `cfg_we` is 1. `cfg_sel` 0 writes the priority byte `cfg_wdata` to source `cfg_idx`. Sel 1 writes the non-maskable flag from `cfg_wdata[0]`. Sel 2 writes the group bit from `cfg_wdata[0]`. Sel 3 writes the global security-disable bit from `cfg_wdata[0]`. Reset values: priority 0xFF and all bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config field select (see R12) |
| cfg_idx | input | IDX_W | Source index for per-source writes |
| cfg_wdata | input | 8 | Config write data |
| pend | input | NUM_SRC | Pending bit per source |
| ext_en | input | 1 | External candidate enable |
| ext_id | input | ID_W | External candidate interrupt number |
| ext_prio | input | 8 | External candidate priority |
| start | input | 1 | Sweep request pulse |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle result-ready pulse |
| best_id | output | ID_W | Winning interrupt number |
| best_prio | output | 8 | Winning effective priority |
| best_super | output | 1 | Winning candidate is non-maskable |
| best_valid | output | 1 | Winning priority is not 0xFF |

## Verification
Two things can happen in the same cycle: the external-candidate comparison that ends a sweep, and a fresh start request. When they meet, the block must publish the old result and clear the running best for a new sweep at a single edge. The bench provokes this by pulsing start exactly in the external-compare cycle, and again by pulsing it several times mid-sweep. A behavioural model steps alongside the design every clock. The directed checks then require the second done to appear exactly NUM_SRC+1 cycles after the first, with busy held high between them, and no third sweep.

// File: rtl/irq_pick_pkg.sv
// Package: shared constants, enums and the effective-priority rule for the
// pending interrupt priority selector. Assumes 8-bit priority bytes.
package irq_pick_pkg;

    typedef logic [7:0] prio_t;

    localparam prio_t PRIO_NONE   = 8'hFF;
    localparam prio_t PRIO_NMI_NS = 8'h80;
    localparam prio_t PRIO_NMI_S  = 8'h00;

    typedef enum logic [1:0] {
        CF_PRIO   = 2'd0,
        CF_SUPER  = 2'd1,
        CF_GROUP  = 2'd2,
        CF_GLOBAL = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_EXT  = 2'd2
    } seq_e;

    // Effective priority: non-maskable sources get a forced level.
    function automatic prio_t eff_prio(prio_t p, logic sup, logic grp, logic ds);
        if (!sup)
            return p;
        if (!ds && grp)
            return PRIO_NMI_NS;
        return PRIO_NMI_S;
    endfunction

endpackage

// File: rtl/irq_cfg_bank.sv
// Config bank: holds per-source priority byte, non-maskable flag and group
// bit, plus the global security-disable bit. Writes act at the clock edge.
// Assumes cfg_idx values at or above NUM_SRC address nothing.
module irq_cfg_bank
    import irq_pick_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [7:0]            cfg_wdata,
    output logic [NUM_SRC*8-1:0]  prio_flat,
    output logic [NUM_SRC-1:0]    sup_q,
    output logic [NUM_SRC-1:0]    grp_q,
    output logic                  ds_q
);

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            logic hit;
            assign hit = cfg_we && (cfg_idx == IDX_W'(g));

            // Per-source register file entry update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prio_flat[g*8 +: 8] <= PRIO_NONE;
                    sup_q[g]            <= 1'b0;
                    grp_q[g]            <= 1'b0;
                end else if (hit) begin
                    if (cfg_sel == CF_PRIO)
                        prio_flat[g*8 +: 8] <= cfg_wdata;
                    if (cfg_sel == CF_SUPER)
                        sup_q[g] <= cfg_wdata[0];
                    if (cfg_sel == CF_GROUP)
                        grp_q[g] <= cfg_wdata[0];
                end
            end
        end
    endgenerate

    // Global security-disable bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ds_q <= 1'b0;
        else if (cfg_we && cfg_sel == CF_GLOBAL)
            ds_q <= cfg_wdata[0];
    end

    p_global_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CF_GLOBAL) |=> (ds_q == $past(cfg_wdata[0])));

endmodule

// File: rtl/irq_eff_prio.sv
// Effective priority stage: per source, replaces the programmed byte with the
// forced non-maskable level where the flag is set. Purely combinational.
module irq_eff_prio
    import irq_pick_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC*8-1:0] prio_flat,
    input  logic [NUM_SRC-1:0]   sup_q,
    input  logic [NUM_SRC-1:0]   grp_q,
    input  logic                 ds_q,
    output logic [NUM_SRC*8-1:0] eff_flat
);

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_eff
            // Apply the security-dependent forcing rule to one source.
            always_comb begin
                eff_flat[g*8 +: 8] = eff_prio(prio_flat[g*8 +: 8], sup_q[g], grp_q[g], ds_q);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_scan_seq.sv
// Sweep sequencer: idle -> one cycle per source in ascending order -> one
// external-compare cycle. Latches start requests seen mid-sweep and restarts
// at the end of the sweep. Assumes NUM_SRC >= 1.
module irq_scan_seq
    import irq_pick_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             clear,
    output logic             step_src,
    output logic             step_ext,
    output logic             busy,
    output logic [IDX_W-1:0] cur_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    seq_e state_q;
    logic again_q;

    // Decode phase strobes and the clear request for the running best.
    always_comb begin
        step_src = (state_q == SQ_SCAN);
        step_ext = (state_q == SQ_EXT);
        busy     = (state_q != SQ_IDLE);
        clear    = ((state_q == SQ_IDLE) && start) ||
                   ((state_q == SQ_EXT) && (start || again_q));
    end

    // Advance the sweep state, index and pending-restart latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur_idx <= '0;
            again_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_SCAN;
                        cur_idx <= '0;
                    end
                end
                SQ_SCAN: begin
                    if (start)
                        again_q <= 1'b1;
                    if (cur_idx == LAST)
                        state_q <= SQ_EXT;
                    else
                        cur_idx <= cur_idx + 1'b1;
                end
                SQ_EXT: begin
                    again_q <= 1'b0;
                    if (start || again_q) begin
                        state_q <= SQ_SCAN;
                        cur_idx <= '0;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ext && again_q) |=> (step_src && cur_idx == '0));

    p_idle_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (step_src && cur_idx == '0));

endmodule

// File: rtl/irq_best_reg.sv
// Running-best tracker and result register: compares the current candidate
// (a pending source, or the external one) with the running best, and at the
// external-compare step publishes the final pick with a done pulse.
// Assumes ID_W > IDX_W so source indices and external numbers share one space.
module irq_best_reg
    import irq_pick_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4,
    parameter int ID_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step_src,
    input  logic                 step_ext,
    input  logic [IDX_W-1:0]     cur_idx,
    input  logic [NUM_SRC-1:0]   pend,
    input  logic [NUM_SRC*8-1:0] eff_flat,
    input  logic [NUM_SRC-1:0]   sup_q,
    input  logic                 ext_en,
    input  logic [ID_W-1:0]      ext_id,
    input  logic [7:0]           ext_prio,
    output logic [ID_W-1:0]      best_id,
    output logic [7:0]           best_prio,
    output logic                 best_super,
    output logic                 best_valid,
    output logic                 done
);

    localparam logic [ID_W-1:0] ID_NONE = '1;

    logic [ID_W-1:0] run_id;
    prio_t           run_prio;
    logic            run_sup;

    logic [ID_W-1:0] c_id;
    prio_t           c_prio;
    logic            c_sup;
    logic            c_ok;
    logic            c_wins;

    logic [ID_W-1:0] f_id;
    prio_t           f_prio;
    logic            f_sup;

    // Select the candidate for this step.
    always_comb begin
        c_id   = ID_W'(cur_idx);
        c_prio = eff_flat[cur_idx*8 +: 8];
        c_sup  = sup_q[cur_idx];
        c_ok   = step_src && pend[cur_idx];
        if (step_ext) begin
            c_id   = ext_id;
            c_prio = ext_prio;
            c_sup  = 1'b0;
            c_ok   = ext_en && (ext_prio != PRIO_NONE);
        end
    end

    // Ordering: priority first, then flag, then lower-or-equal number.
    always_comb begin
        if (c_prio != run_prio)
            c_wins = (c_prio < run_prio);
        else if (c_sup != run_sup)
            c_wins = c_sup;
        else
            c_wins = (c_id <= run_id);
    end

    // Final pick at the external step.
    always_comb begin
        if (c_ok && c_wins) begin
            f_id   = c_id;
            f_prio = c_prio;
            f_sup  = c_sup;
        end else begin
            f_id   = run_id;
            f_prio = run_prio;
            f_sup  = run_sup;
        end
    end

    // Track the running best across the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_id   <= ID_NONE;
            run_prio <= PRIO_NONE;
            run_sup  <= 1'b0;
        end else if (step_src && c_ok && c_wins) begin
            run_id   <= c_id;
            run_prio <= c_prio;
            run_sup  <= c_sup;
        end
    end

    // Publish the result and pulse done at the end of a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_id    <= ID_NONE;
            best_prio  <= PRIO_NONE;
            best_super <= 1'b0;
            best_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= step_ext;
            if (step_ext) begin
                best_id    <= f_id;
                best_prio  <= f_prio;
                best_super <= f_sup;
                best_valid <= (f_prio != PRIO_NONE);
            end
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_id) && $stable(best_prio) && $stable(best_super)));

    p_nmi_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && best_super) |-> (best_prio == PRIO_NMI_NS || best_prio == PRIO_NMI_S));

    p_ext_nosuper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_ext |=> (!best_super || $past(run_sup)));

    p_mono_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_src |=> (run_prio <= $past(run_prio)));

endmodule

// File: rtl/irq_pick_top.sv
// Top: pending interrupt priority selector. Wires the config bank, the
// effective-priority stage, the sweep sequencer and the best tracker.
// Assumes ID_W is wider than the source index.
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ID_W    = 10,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_wdata,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               ext_en,
    input  logic [ID_W-1:0]    ext_id,
    input  logic [7:0]         ext_prio,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [ID_W-1:0]    best_id,
    output logic [7:0]         best_prio,
    output logic               best_super,
    output logic               best_valid
);

    logic [NUM_SRC*8-1:0] prio_flat;
    logic [NUM_SRC*8-1:0] eff_flat;
    logic [NUM_SRC-1:0]   sup_q;
    logic [NUM_SRC-1:0]   grp_q;
    logic                 ds_q;
    logic                 clear;
    logic                 step_src;
    logic                 step_ext;
    logic [IDX_W-1:0]     cur_idx;

    irq_cfg_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .prio_flat(prio_flat),
        .sup_q(sup_q), .grp_q(grp_q), .ds_q(ds_q)
    );

    irq_eff_prio #(.NUM_SRC(NUM_SRC)) u_eff (
        .prio_flat(prio_flat), .sup_q(sup_q), .grp_q(grp_q), .ds_q(ds_q),
        .eff_flat(eff_flat)
    );

    irq_scan_seq #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .step_src(step_src), .step_ext(step_ext), .busy(busy), .cur_idx(cur_idx)
    );

    irq_best_reg #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ID_W(ID_W)) u_best (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step_src(step_src),
        .step_ext(step_ext), .cur_idx(cur_idx), .pend(pend), .eff_flat(eff_flat),
        .sup_q(sup_q), .ext_en(ext_en), .ext_id(ext_id), .ext_prio(ext_prio),
        .best_id(best_id), .best_prio(best_prio), .best_super(best_super),
        .best_valid(best_valid), .done(done)
    );

endmodule

// File: tb/sim_irq_pick_top.sv
module sim_irq_pick_top;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 16;
    localparam int IDW  = 10;
    localparam int IXW  = 4;
    localparam int NONE_ID = (1 << IDW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [IXW-1:0] cfg_idx = '0;
    logic [7:0]     cfg_wdata = '0;
    logic [N-1:0]   pend = '0;
    logic           ext_en = 1'b0;
    logic [IDW-1:0] ext_id = '0;
    logic [7:0]     ext_prio = 8'hFF;
    logic           start = 1'b0;
    logic           busy, done, best_super, best_valid;
    logic [IDW-1:0] best_id;
    logic [7:0]     best_prio;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    irq_pick_top #(.NUM_SRC(N), .ID_W(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .pend(pend), .ext_en(ext_en),
        .ext_id(ext_id), .ext_prio(ext_prio), .start(start), .busy(busy),
        .done(done), .best_id(best_id), .best_prio(best_prio),
        .best_super(best_super), .best_valid(best_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_prio[N];
    bit m_sup[N];
    bit m_grp[N];
    bit m_ds;
    int ph;          // 0 idle, 1 sweeping sources, 2 external compare
    int pos;
    bit again;
    int r_id, r_prio;
    bit r_sup;
    int o_id, o_prio;
    bit o_sup, o_done;

    function automatic int m_eff(int i);
        if (!m_sup[i]) return m_prio[i];
        if (!m_ds && m_grp[i]) return 'h80;
        return 0;
    endfunction

    function automatic bit m_better(int cp, bit cs, int cid, int bp, bit bs, int bid);
        if (cp != bp) return cp < bp;
        if (cs != bs) return cs;
        return cid <= bid;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 'hFF; m_sup[i] = 0; m_grp[i] = 0;
            end
            m_ds = 0; ph = 0; pos = 0; again = 0;
            r_id = NONE_ID; r_prio = 'hFF; r_sup = 0;
            o_id = NONE_ID; o_prio = 'hFF; o_sup = 0; o_done = 0;
        end else begin
            o_done = 0;
            if (ph == 1) begin
                if (pend[pos] && m_better(m_eff(pos), m_sup[pos], pos, r_prio, r_sup, r_id)) begin
                    r_prio = m_eff(pos); r_sup = m_sup[pos]; r_id = pos;
                end
                if (start) again = 1;
                if (pos == N-1) ph = 2; else pos++;
            end else if (ph == 2) begin
                if (ext_en && ext_prio != 8'hFF &&
                    m_better(ext_prio, 0, ext_id, r_prio, r_sup, r_id)) begin
                    r_prio = ext_prio; r_sup = 0; r_id = ext_id;
                end
                o_id = r_id; o_prio = r_prio; o_sup = r_sup; o_done = 1;
                if (start || again) begin
                    ph = 1; pos = 0; again = 0;
                    r_id = NONE_ID; r_prio = 'hFF; r_sup = 0;
                end else begin
                    ph = 0;
                end
            end else if (start) begin
                ph = 1; pos = 0;
                r_id = NONE_ID; r_prio = 'hFF; r_sup = 0;
            end
            if (cfg_we) begin
                if (cfg_sel == 2'd3) m_ds = cfg_wdata[0];
                else if (cfg_sel == 2'd0) m_prio[cfg_idx] = cfg_wdata;
                else if (cfg_sel == 2'd1) m_sup[cfg_idx] = cfg_wdata[0];
                else m_grp[cfg_idx] = cfg_wdata[0];
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model each cycle (R9 timing, R10 valid).
    always @(negedge clk) begin
        if (rst_n && cyc > 2) begin
            chk(best_id == IDW'(o_id), "R9", "model best_id", best_id, o_id);
            chk(best_prio == 8'(o_prio), "R1", "model best_prio", best_prio, o_prio);
            chk(best_super == o_sup, "R2", "model best_super", best_super, o_sup);
            chk(best_valid == (o_prio != 'hFF), "R10", "model best_valid", best_valid, o_prio != 'hFF);
            chk(done == o_done, "R9", "model done", done, o_done);
            chk(busy == (ph != 0), "R11", "model busy", busy, ph != 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic wr(int sel, int idx, int data);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = IXW'(idx); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic sweep(output int lat);
        lat = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_res(string req, int id, int pr, bit sp);
        chk(best_id == IDW'(id), req, "best_id", best_id, id);
        chk(best_prio == 8'(pr), req, "best_prio", best_prio, pr);
        chk(best_super == sp, req, "best_super", best_super, sp);
        chk(best_valid == (pr != 'hFF), "R10", "best_valid", best_valid, pr != 'hFF);
    endtask

    initial begin
        int lat;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R6 reset state
        chk(best_id == IDW'(NONE_ID) && best_prio == 8'hFF && !best_super &&
            !best_valid && !done && !busy, "R6", "reset outputs",
            {best_prio, best_super, best_valid, done, busy}, 'hFF0);

        // R5 R1 R12: plain priorities, lower numeric wins
        wr(0, 3, 'h40); wr(0, 7, 'h20);
        pend = 16'h0088;
        sweep(lat);
        chk(lat == N + 2, "R9", "done latency", lat, N + 2);
        expect_res("R5", 7, 'h20, 0);

        // R8: non-pending better source ignored
        pend = 16'h0008;
        sweep(lat);
        expect_res("R8", 3, 'h40, 0);

        // R4 secure non-maskable -> 0x00
        wr(1, 5, 1); wr(0, 5, 'hC0);
        pend = 16'h00A8;
        sweep(lat);
        expect_res("R4", 5, 'h00, 1);

        // R4 non-secure, ds=0 -> 0x80; R2 equal prio, flag beats lower id
        wr(2, 5, 1); wr(0, 2, 'h80);
        pend = 16'h0024;
        sweep(lat);
        expect_res("R2", 5, 'h80, 1);

        // R1: lower numeric ordinary beats flagged
        pend = 16'h00A4;
        sweep(lat);
        expect_res("R1", 7, 'h20, 0);

        // R4 ds=1 -> 0x00 even for non-secure group
        wr(3, 0, 1);
        pend = 16'h0024;
        sweep(lat);
        expect_res("R4", 5, 'h00, 1);
        wr(3, 0, 0);

        // R3 tie on priority and flag: lower index wins
        wr(0, 9, 'h30); wr(0, 11, 'h30);
        pend = 16'h0A00;
        ext_en = 1; ext_prio = 'h30; ext_id = 12;
        sweep(lat);
        expect_res("R3", 9, 'h30, 0);
        // R3 equal number replaces (external id 9, same priority)
        ext_id = 9;
        sweep(lat);
        expect_res("R3", 9, 'h30, 0);
        // R7 external with lower number wins, never flagged
        ext_id = 3;
        sweep(lat);
        expect_res("R7", 3, 'h30, 0);
        // R7 external beats flagged source only by lower priority
        pend = 16'h0020; ext_prio = 'h10; ext_id = 600;
        sweep(lat);
        expect_res("R7", 600, 'h10, 0);
        // R7 external with 0xFF ignored
        pend = 16'h0800; ext_prio = 'hFF; ext_id = 1;
        sweep(lat);
        expect_res("R7", 11, 'h30, 0);
        // R7 external disabled ignored
        ext_en = 0; ext_prio = 'h01;
        sweep(lat);
        expect_res("R7", 11, 'h30, 0);

        // R6 rescan starts empty; R10 nothing pending -> invalid
        pend = '0;
        sweep(lat);
        expect_res("R6", NONE_ID, 'hFF, 0);

        // R11 starts mid-sweep merge into one extra sweep
        pend = 16'h0008;
        start = 1; @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        start = 1; @(negedge clk); start = 0;
        pend = 16'h0080;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        expect_res("R11", 7, 'h20, 0);
        gap = 0;
        @(negedge clk); gap++;
        chk(busy == 1, "R11", "busy after first done", busy, 1);
        while (!done && gap < 100) begin @(negedge clk); gap++; end
        chk(gap == N + 1, "R11", "restart spacing", gap, N + 1);
        expect_res("R11", 7, 'h20, 0);
        @(negedge clk);
        chk(busy == 0, "R11", "no third sweep", busy, 0);

        // R11 start exactly in the external-compare cycle
        pend = 16'h0008;
        start = 1; @(negedge clk); start = 0;
        repeat (N) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        chk(done == 1, "R11", "done with coincident start", done, 1);
        chk(busy == 1, "R11", "busy with coincident start", busy, 1);
        gap = 0;
        while (gap < 100) begin
            @(negedge clk); gap++;
            if (done) break;
        end
        chk(gap == N + 1, "R11", "coincident restart spacing", gap, N + 1);
        expect_res("R11", 3, 'h40, 0);
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule